// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver

This block moves data between two buses, A and B, with one independent path in each direction. Each path has one storage element per bit. That element acts as a level-sensitive latch while the path's latch enable is HIGH. While the latch enable is LOW, it acts as an edge-triggered register that loads on a rising edge of the path's bus clock, but only when the active-low clock enable is LOW. The far bus is either driven from the path or left floating, under an active-low output enable.

The block runs on a fast system clock. Each bus clock is treated as a sampled signal, and its rising edge is found by comparing it with its registered previous value. The latch enable is also evaluated as a sampled level. The tri-state output of each path is modelled as a data vector plus a drive flag. In a transparent path the output follows the input within the same cycle. A captured value appears on the output one system clock after the cycle in which the edge is sampled.

Top module: `xcvr_top`

## Requirements
- R1: While a path's output enable is HIGH, its drive flag is 0 and its output data reads all zeros, whatever the latch enable, bus clock, clock enable and input data are.
- R2: With the output enabled and the latch enable HIGH, the output equals the input in the same system cycle, whatever the bus clock and clock enable are.
- R3: With the latch enable LOW and the clock enable LOW, a bus clock that is sampled LOW and then HIGH on the next system clock loads the input present in that HIGH cycle. The output shows the loaded value from the following cycle.
- R4: With the latch enable LOW and the clock enable HIGH, rising bus clock edges leave the stored value and the output unchanged.
- R5: With the latch enable LOW and the bus clock held steady (HIGH or LOW), the stored value does not change.
- R6: After the latch enable falls, the output keeps the input value of the last cycle in which the latch enable was HIGH, as long as no clock edge is captured.
- R7: The A-to-B and B-to-A paths use separate controls and behave identically. Activity on one path never changes the other path's output.
- R8: Reset clears both stores to zero and starts both edge detectors in the HIGH state. A bus clock that is HIGH when reset is released therefore causes no capture.
- R9: The store keeps updating while the output is disabled, so the value loaded in that time appears on the bus once the output is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | W | Data read from bus A |
| b_in | input | W | Data read from bus B |
| ab_oe_n | input | 1 | A-to-B output enable, active LOW |
| ab_le | input | 1 | A-to-B latch enable, transparent when HIGH |
| ab_bclk | input | 1 | A-to-B bus clock, sampled |
| ab_cen_n | input | 1 | A-to-B clock enable, active LOW |
| ba_oe_n | input | 1 | B-to-A output enable, active LOW |
| ba_le | input | 1 | B-to-A latch enable, transparent when HIGH |
| ba_bclk | input | 1 | B-to-A bus clock, sampled |
| ba_cen_n | input | 1 | B-to-A clock enable, active LOW |
| b_out | output | W | Data driven onto bus B |
| b_drive | output | 1 | Bus B driver enable (0 means floating) |
| a_out | output | W | Data driven onto bus A |
| a_drive | output | 1 | Bus A driver enable (0 means floating) |

## Verification
A wrong store value stays hidden while a path is transparent or disabled. It shows on the output in the first cycle that the path is enabled with its latch enable LOW, which can be many cycles after the faulty update. For that reason the bench runs long stretches of held mode. A wrong edge detector shows one system cycle after the bad sample, as a missed or extra load. The reset-release case, where the bus clock is already HIGH, shows at once as a nonzero output.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int NDIR = 2;
  localparam int DIR_AB = 0;
  localparam int DIR_BA = 1;

  // rising edge of a sampled bus clock
  function automatic logic rise_seen(input logic now_lvl, input logic prev_lvl);
    return now_lvl & ~prev_lvl;
  endfunction

  // load condition while the latch is closed
  function automatic logic load_on_edge(input logic le, input logic rise, input logic cen_n);
    return ~le & rise & ~cen_n;
  endfunction
endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge #(
  parameter logic RESET_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  import xcvr_pkg::*;
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RESET_LVL;
    else        prev_q <= lvl;
  end

  assign rise = rise_seen(lvl, prev_q);
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic take;
  assign take = le | load;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q[i] <= 1'b0;
      else if (take) q[i] <= d[i];
    end
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         oe_n,
  input  logic         le,
  input  logic         bclk,
  input  logic         cen_n,
  output logic [W-1:0] dout,
  output logic         drive,
  output logic [W-1:0] store,
  output logic         cap
);
  import xcvr_pkg::*;
  logic rise;
  logic [W-1:0] shown;

  xcvr_edge #(.RESET_LVL(1'b1)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(bclk), .rise(rise)
  );

  assign cap = load_on_edge(le, rise, cen_n);

  xcvr_store #(.W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .le(le), .load(cap), .d(din), .q(store)
  );

  assign shown = le ? din : store;
  assign drive = ~oe_n;
  assign dout  = drive ? shown : '0;
endmodule

// File: rtl/xcvr_top.sv
module xcvr_top #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_oe_n,
  input  logic         ab_le,
  input  logic         ab_bclk,
  input  logic         ab_cen_n,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_bclk,
  input  logic         ba_cen_n,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  output logic [W-1:0] a_out,
  output logic         a_drive
);
  import xcvr_pkg::*;

  logic [W-1:0] din_v   [NDIR];
  logic [W-1:0] dout_v  [NDIR];
  logic [W-1:0] store_v [NDIR];
  logic         oe_v    [NDIR];
  logic         le_v    [NDIR];
  logic         bclk_v  [NDIR];
  logic         cen_v   [NDIR];
  logic         drv_v   [NDIR];
  logic         cap_v   [NDIR];

  // named internal events for the checker
  logic [W-1:0] ab_store, ba_store;
  logic         ab_cap, ba_cap;

  assign din_v[DIR_AB]  = a_in;     assign din_v[DIR_BA]  = b_in;
  assign oe_v[DIR_AB]   = ab_oe_n;  assign oe_v[DIR_BA]   = ba_oe_n;
  assign le_v[DIR_AB]   = ab_le;    assign le_v[DIR_BA]   = ba_le;
  assign bclk_v[DIR_AB] = ab_bclk;  assign bclk_v[DIR_BA] = ba_bclk;
  assign cen_v[DIR_AB]  = ab_cen_n; assign cen_v[DIR_BA]  = ba_cen_n;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    xcvr_lane #(.W(W)) u_lane (
      .clk(clk), .rst_n(rst_n), .din(din_v[d]), .oe_n(oe_v[d]),
      .le(le_v[d]), .bclk(bclk_v[d]), .cen_n(cen_v[d]),
      .dout(dout_v[d]), .drive(drv_v[d]), .store(store_v[d]), .cap(cap_v[d])
    );
  end

  assign b_out    = dout_v[DIR_AB];
  assign b_drive  = drv_v[DIR_AB];
  assign a_out    = dout_v[DIR_BA];
  assign a_drive  = drv_v[DIR_BA];
  assign ab_store = store_v[DIR_AB];
  assign ba_store = store_v[DIR_BA];
  assign ab_cap   = cap_v[DIR_AB];
  assign ba_cap   = cap_v[DIR_BA];
endmodule

// File: rtl/xcvr_top_chk.sv
module xcvr_top_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         ab_oe_n,
  input logic         ab_le,
  input logic         ab_bclk,
  input logic         ab_cen_n,
  input logic         ba_oe_n,
  input logic         ba_le,
  input logic         ba_bclk,
  input logic         ba_cen_n,
  input logic [W-1:0] b_out,
  input logic         b_drive,
  input logic [W-1:0] a_out,
  input logic         a_drive,
  input logic [W-1:0] ab_store,
  input logic [W-1:0] ba_store,
  input logic         ab_cap,
  input logic         ba_cap
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_AB_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    ab_oe_n |-> (!b_drive && b_out == '0)); // R1
  AST_BA_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    ba_oe_n |-> (!a_drive && a_out == '0)); // R1
  AST_AB_TRANSP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_oe_n && ab_le) |-> (b_out == a_in)); // R2
  AST_BA_TRANSP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_oe_n && ba_le) |-> (a_out == b_in)); // R2
  AST_AB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ab_cap |=> (ab_store == $past(a_in))); // R3
  AST_BA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ba_cap |=> (ba_store == $past(b_in))); // R3
  AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && !ab_cap) |=> $stable(ab_store)); // R5
  AST_BA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_le && !ba_cap) |=> $stable(ba_store)); // R5
  AST_AB_NOEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_cen_n || ab_le) |-> !ab_cap); // R4
  AST_AB_LEFALL: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $fell(ab_le) && !ab_oe_n) |-> (b_out == $past(a_in))); // R6
  AST_BA_LEFALL: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $fell(ba_le) && !ba_oe_n) |-> (a_out == $past(b_in))); // R6
endmodule

bind xcvr_top xcvr_top_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
  .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_bclk(ab_bclk), .ab_cen_n(ab_cen_n),
  .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_bclk(ba_bclk), .ba_cen_n(ba_cen_n),
  .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive),
  .ab_store(ab_store), .ba_store(ba_store), .ab_cap(ab_cap), .ba_cap(ba_cap)
);

// File: tb/xcvr_top_test.sv
module xcvr_top_test;
  localparam int W = 18;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_oe_n = 0, ab_le = 0, ab_bclk = 1, ab_cen_n = 0;
  logic ba_oe_n = 0, ba_le = 0, ba_bclk = 1, ba_cen_n = 0;
  logic [W-1:0] b_out, a_out;
  logic b_drive, a_drive;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [W-1:0] data;
    logic         drv;
    string        tag;
  } exp_t;
  exp_t q_ab[$];
  exp_t q_ba[$];

  // reference state per direction
  logic [W-1:0] m_q [2];
  logic         m_prev [2];

  always #5 clk = ~clk;

  xcvr_top #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_bclk(ab_bclk), .ab_cen_n(ab_cen_n),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_bclk(ba_bclk), .ba_cen_n(ba_cen_n),
    .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
  );

  function automatic exp_t predict(int d, logic [W-1:0] din, logic oe_n, logic le, string tag);
    exp_t e;
    e.drv  = !oe_n;
    e.data = oe_n ? '0 : (le ? din : m_q[d]);
    e.tag  = tag;
    return e;
  endfunction

  task automatic advance(int d, logic [W-1:0] din, logic le, logic ck, logic cen_n);
    if (le) m_q[d] = din;
    else if (ck && !m_prev[d] && !cen_n) m_q[d] = din;
    m_prev[d] = ck;
  endtask

  // driver: called right after a falling edge with inputs already set
  task automatic cyc(string tag_ab, string tag_ba);
    q_ab.push_back(predict(0, a_in, ab_oe_n, ab_le, tag_ab));
    q_ba.push_back(predict(1, b_in, ba_oe_n, ba_le, tag_ba));
    @(posedge clk);
    advance(0, a_in, ab_le, ab_bclk, ab_cen_n);
    advance(1, b_in, ba_le, ba_bclk, ba_cen_n);
    @(negedge clk);
  endtask

  task automatic compare(string dir, exp_t e, logic [W-1:0] data, logic drv);
    checks++;
    if (data !== e.data || drv !== e.drv) begin
      failures++;
      $display("FAIL %s %s: got data=%h drive=%b expected data=%h drive=%b",
               e.tag, dir, data, drv, e.data, e.drv);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (q_ab.size() > 0) compare("A->B", q_ab.pop_front(), b_out, b_drive);
      if (q_ba.size() > 0) compare("B->A", q_ba.pop_front(), a_out, a_drive);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got no end expected end");
    finish_run();
  end

  initial begin
    m_q[0] = '0; m_q[1] = '0; m_prev[0] = 1'b1; m_prev[1] = 1'b1;
    a_in = 18'h2A5A5; b_in = 18'h15A5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8: bus clock already HIGH, clock enable LOW: no load at release
    cyc("R8", "R8");
    cyc("R8", "R8");

    // R1: disabled outputs float even when transparent
    ab_oe_n = 1; ab_le = 1; ba_oe_n = 1; ba_le = 1;
    a_in = 18'h3FFFF; b_in = 18'h00F0F;
    cyc("R1", "R1");
    ab_bclk = 0; ba_bclk = 0;
    cyc("R1", "R1");

    // R2: transparent path follows the input
    ab_oe_n = 0; ba_oe_n = 0;
    for (int i = 0; i < 4; i++) begin
      a_in = 18'h01234 + i * 18'h1111; b_in = 18'h2AAAA ^ (i * 18'h0333);
      ab_bclk = i[0]; ab_cen_n = i[1];
      cyc("R2", "R2");
    end

    // R6: latch enable falls; output keeps last transparent input
    a_in = 18'h0BEEF; b_in = 18'h1CAFE; ab_bclk = 1; ba_bclk = 1;
    cyc("R2", "R2");
    ab_le = 0; ba_le = 0; a_in = 18'h00001; b_in = 18'h00002;
    cyc("R6", "R6");
    a_in = 18'h3C3C3; b_in = 18'h03C3C;
    cyc("R6", "R6");

    // R5: clock static HIGH then LOW, enable LOW
    ab_cen_n = 0; ba_cen_n = 0;
    repeat (2) begin a_in = a_in + 18'd7; cyc("R5", "R5"); end
    ab_bclk = 0; ba_bclk = 0;
    repeat (2) begin a_in = a_in + 18'd7; cyc("R5", "R5"); end

    // R3: edge with enable LOW loads; shows next cycle
    a_in = 18'h12345; b_in = 18'h23456; ab_bclk = 1; ba_bclk = 1;
    cyc("R3", "R3");
    a_in = 18'h00000; b_in = 18'h3FFFF;
    cyc("R3", "R3");
    ab_bclk = 0; ba_bclk = 0;
    cyc("R3", "R3");

    // R4: edges with clock enable HIGH are ignored
    ab_cen_n = 1; ba_cen_n = 1;
    for (int i = 0; i < 3; i++) begin
      a_in = 18'h11111 * (i + 1); b_in = 18'h05555 + i;
      ab_bclk = 1; ba_bclk = 1; cyc("R4", "R4");
      ab_bclk = 0; ba_bclk = 0; cyc("R4", "R4");
    end

    // R9: load while disabled, then enable
    ab_cen_n = 0; ab_oe_n = 1; a_in = 18'h2F0F0;
    ab_bclk = 1; cyc("R9", "R7");
    a_in = 18'h0; ab_bclk = 0; cyc("R9", "R7");
    ab_oe_n = 0; cyc("R9", "R7");

    // R7: independent random activity on both paths
    for (int i = 0; i < 3000; i++) begin
      a_in = W'($urandom); b_in = W'($urandom);
      ab_oe_n = ($urandom % 5) == 0; ba_oe_n = ($urandom % 5) == 0;
      ab_le = ($urandom % 4) == 0;   ba_le = ($urandom % 4) == 0;
      ab_bclk = $urandom; ba_bclk = $urandom;
      ab_cen_n = ($urandom % 3) == 0; ba_cen_n = ($urandom % 3) == 0;
      cyc("R7", "R7");
    end
    @(negedge clk);
    #4;
    finish_run();
  end
endmodule